// File: doc/BRIEF.md
# Nested Hardware Loop Controller

This block lets an instruction sequencer run counted loops with no branch instruction at the loop end. It holds two loop units. Each unit keeps a first-instruction address, a last-instruction address and a remaining-pass count. Every cycle the sequencer presents the address it is fetching. When that address equals the last address of a live unit, the block sends fetch back to the first address in the same cycle and counts the pass off. Loops nest: the higher-numbered unit is the inner one.

A setup port loads all three registers of one unit at once. A separate write port and a read port reach each register on its own, so that software can spill loop state around an interrupt and restore it. A four-entry loop buffer captures the instructions at the start of the loop being run. It supplies them on later passes, so a body of four instructions or fewer needs no memory fetch after its first pass. A loop whose first address is not right after its setup instruction pays a fixed stall on its first jump back.

Top module: `loop_ctl`

## Requirements
- R1: After reset every unit count reads 0, `redirect_o` and `stall_o` are low, and the loop buffer holds no valid entry.
- R2: On a fetch step whose address equals a unit's bottom and whose count is above 1, `redirect_o` is high and `next_pc_o` equals that unit's top in the same cycle, and the count drops by one at the edge. With count 1 the count drops to 0, there is no redirect and `next_pc_o` is the address plus 1. A count of N therefore runs the body N times.
- R3: A unit whose count is 0 never redirects, so its body runs exactly once.
- R4: A setup operation writes top, bottom and count of the selected unit in one edge and leaves the other unit untouched.
- R5: Single-register writes and reads use select 0 = top, 1 = bottom, 2 = count. Select 3 reads 0 and a write with select 3 changes nothing.
- R6: When two units share the matched bottom address, unit 1 is serviced first. In the same step unit 0 is examined only if unit 1 is on its final pass (count 1).
- R7: A taken branch at a loop bottom suppresses the loopback and leaves every count unchanged.
- R8: If a setup places the loop top anywhere other than the setup address plus 1, the first redirect of that unit is followed by `stall_o` high for 4 cycles. During those cycles fetch steps are ignored. Later redirects of the same loop add no stall.
- R9: The loop buffer holds 4 consecutive addresses starting at its base. On a hit `fetch_req_o` is low and `instr_o` comes from the buffer. A loop body of at most 4 instructions makes no memory fetch after its first pass.
- R10: A single-register write empties the buffer. A setup empties it and moves its base to the new top. A redirect to a top different from the base moves the base and empties it, while a redirect to the current base keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pc_valid_i | input | 1 | A fetch step is presented this cycle |
| pc_i | input | AW | Address being fetched |
| branch_taken_i | input | 1 | The instruction at `pc_i` is a taken branch |
| setup_en_i | input | 1 | Load one unit's three registers |
| setup_unit_i | input | UW | Unit selected by the setup |
| setup_pc_i | input | AW | Address of the setup instruction |
| setup_top_i | input | AW | New loop top |
| setup_bot_i | input | AW | New loop bottom |
| setup_cnt_i | input | CW | New pass count |
| reg_wr_en_i | input | 1 | Single-register write strobe |
| reg_wr_unit_i | input | UW | Unit written |
| reg_wr_sel_i | input | 2 | Register written (0 top, 1 bottom, 2 count) |
| reg_wr_data_i | input | RW | Write data |
| reg_rd_unit_i | input | UW | Unit read |
| reg_rd_sel_i | input | 2 | Register read |
| reg_rd_data_o | output | RW | Read data, zero-extended |
| mem_data_i | input | IW | Instruction word from memory |
| fetch_req_o | output | 1 | Memory fetch needed for `pc_i` |
| instr_o | output | IW | Instruction for `pc_i` |
| redirect_o | output | 1 | Loopback taken this step |
| next_pc_o | output | AW | Address to fetch next |
| stall_o | output | 1 | Loopback penalty in progress |

## Verification
`redirect_o`, `next_pc_o`, `fetch_req_o` and `instr_o` are combinational results of the presented address and the stored state, so they are due in the same cycle as the step. The bench drives each step at the falling edge and samples these outputs a nanosecond later. Count changes become visible on the read port after the next rising edge. `stall_o` rises one edge after the redirecting step and stays up for four cycles. The bench therefore reads `stall_o` at each falling edge, before it decides whether to present a step, and tallies the stalled cycles per scenario. Address traces, fetch totals and stall totals are compared once each scenario has completed, against values worked out by hand from the requirements.

// File: rtl/loop_ctl_pkg.sv
package loop_ctl_pkg;

    // single-register select codes shared by the write and read ports
    typedef enum logic [1:0] {
        SEL_TOP = 2'd0,
        SEL_BOT = 2'd1,
        SEL_CNT = 2'd2,
        SEL_NONE = 2'd3
    } lreg_sel_e;

endpackage

// File: rtl/loop_unit.sv
module loop_unit
    import loop_ctl_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          setup_i,
    input  logic [AW-1:0] setup_top_i,
    input  logic [AW-1:0] setup_bot_i,
    input  logic [CW-1:0] setup_cnt_i,
    input  logic          setup_arm_i,
    input  logic          wr_en_i,
    input  lreg_sel_e     wr_sel_i,
    input  logic [RW-1:0] wr_data_i,
    input  logic          dec_i,
    output logic [AW-1:0] top_o,
    output logic [AW-1:0] bot_o,
    output logic [CW-1:0] cnt_o,
    output logic          arm_o
);

    typedef struct packed {
        logic [AW-1:0] top;
        logic [AW-1:0] bot;
        logic [CW-1:0] cnt;
        logic          arm;
    } unit_t;

    unit_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // pass counted off; any pending first-loop penalty is consumed
        if (dec_i) begin
            st_d.cnt = st_q.cnt - CW'(1);
            st_d.arm = 1'b0;
        end
        if (wr_en_i) begin
            case (wr_sel_i)
                SEL_TOP: st_d.top = AW'(wr_data_i);
                SEL_BOT: st_d.bot = AW'(wr_data_i);
                SEL_CNT: st_d.cnt = CW'(wr_data_i);
                default: ;
            endcase
        end
        if (setup_i) begin
            st_d.top = setup_top_i;
            st_d.bot = setup_bot_i;
            st_d.cnt = setup_cnt_i;
            st_d.arm = setup_arm_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign top_o = st_q.top;
    assign bot_o = st_q.bot;
    assign cnt_o = st_q.cnt;
    assign arm_o = st_q.arm;

    // a disabled unit (count 0) is never asked to count a pass
    assert_dec_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_i |-> cnt_o != '0);

    // a counted pass lowers the count by exactly one
    assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec_i && !setup_i && !wr_en_i) |=> cnt_o == $past(cnt_o) - CW'(1));

    // setup lands all three registers in one edge
    assert_setup_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        setup_i |=> (top_o == $past(setup_top_i) && bot_o == $past(setup_bot_i)
                     && cnt_o == $past(setup_cnt_i)));

endmodule

// File: rtl/loop_buffer.sv
module loop_buffer #(
    parameter int AW    = 16,
    parameter int IW    = 32,
    parameter int DEPTH = 4,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [AW-1:0] pc_i,
    input  logic          fill_i,
    input  logic [IW-1:0] data_i,
    input  logic          retarget_i,
    input  logic [AW-1:0] retarget_addr_i,
    input  logic          flush_i,
    output logic          hit_o,
    output logic [IW-1:0] data_o
);

    typedef struct packed {
        logic [AW-1:0]             base;
        logic [DEPTH-1:0]          valid;
        logic [DEPTH-1:0][IW-1:0]  word;
    } buf_t;

    buf_t st_d, st_q;

    logic [AW-1:0]   off;
    logic            in_rng;
    logic [IDXW-1:0] idx;
    logic            moved;

    assign off    = pc_i - st_q.base;
    assign in_rng = off < AW'(DEPTH);
    assign idx    = off[IDXW-1:0];
    assign hit_o  = in_rng && st_q.valid[idx];
    assign data_o = st_q.word[idx];
    assign moved  = retarget_i && (retarget_addr_i != st_q.base);

    always_comb begin
        st_d = st_q;
        if (moved) st_d.base = retarget_addr_i;
        if (flush_i || moved) begin
            st_d.valid = '0;
        end else if (fill_i && in_rng && !hit_o) begin
            st_d.valid[idx] = 1'b1;
            st_d.word[idx]  = data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // an emptied buffer cannot hit on the following cycle
    assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> !hit_o);

    // a fill makes that address hit next cycle unless the buffer was disturbed
    assert_fill_hits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fill_i && in_rng && !hit_o && !flush_i && !moved)
        |=> ($stable(pc_i) -> hit_o));

endmodule

// File: rtl/loop_ctl.sv
module loop_ctl
    import loop_ctl_pkg::*;
#(
    parameter int AW        = 16,
    parameter int CW        = 16,
    parameter int IW        = 32,
    parameter int N_UNITS   = 2,
    parameter int BUF_DEPTH = 4,
    parameter int PENALTY   = 4,
    localparam int UW = (N_UNITS > 1) ? $clog2(N_UNITS) : 1,
    localparam int RW = (AW > CW) ? AW : CW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          pc_valid_i,
    input  logic [AW-1:0] pc_i,
    input  logic          branch_taken_i,
    input  logic          setup_en_i,
    input  logic [UW-1:0] setup_unit_i,
    input  logic [AW-1:0] setup_pc_i,
    input  logic [AW-1:0] setup_top_i,
    input  logic [AW-1:0] setup_bot_i,
    input  logic [CW-1:0] setup_cnt_i,
    input  logic          reg_wr_en_i,
    input  logic [UW-1:0] reg_wr_unit_i,
    input  logic [1:0]    reg_wr_sel_i,
    input  logic [RW-1:0] reg_wr_data_i,
    input  logic [UW-1:0] reg_rd_unit_i,
    input  logic [1:0]    reg_rd_sel_i,
    output logic [RW-1:0] reg_rd_data_o,
    input  logic [IW-1:0] mem_data_i,
    output logic          fetch_req_o,
    output logic [IW-1:0] instr_o,
    output logic          redirect_o,
    output logic [AW-1:0] next_pc_o,
    output logic          stall_o
);

    localparam int PW = $clog2(PENALTY + 1);

    typedef struct packed {
        logic [PW-1:0] pen;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [AW-1:0] u_top [N_UNITS];
    logic [AW-1:0] u_bot [N_UNITS];
    logic [CW-1:0] u_cnt [N_UNITS];
    logic          u_arm [N_UNITS];
    logic [N_UNITS-1:0] dec_v;

    logic          step;
    logic          setup_arm;
    logic          pen_load;
    logic          buf_hit;
    logic [IW-1:0] buf_data;
    logic [AW-1:0] target;

    assign stall_o   = (st_q.pen != '0);
    assign step      = pc_valid_i && !stall_o;
    assign setup_arm = (setup_top_i != setup_pc_i + AW'(1));

    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        loop_unit #(.AW(AW), .CW(CW), .RW(RW)) i_unit (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .setup_i     (setup_en_i && (setup_unit_i == UW'(g))),
            .setup_top_i (setup_top_i),
            .setup_bot_i (setup_bot_i),
            .setup_cnt_i (setup_cnt_i),
            .setup_arm_i (setup_arm),
            .wr_en_i     (reg_wr_en_i && (reg_wr_unit_i == UW'(g))),
            .wr_sel_i    (lreg_sel_e'(reg_wr_sel_i)),
            .wr_data_i   (reg_wr_data_i),
            .dec_i       (dec_v[g]),
            .top_o       (u_top[g]),
            .bot_o       (u_bot[g]),
            .cnt_o       (u_cnt[g]),
            .arm_o       (u_arm[g])
        );
    end

    // loopback arbitration: highest unit index is the innermost loop
    always_comb begin
        logic claimed;
        claimed    = 1'b0;
        dec_v      = '0;
        redirect_o = 1'b0;
        pen_load   = 1'b0;
        target     = pc_i + AW'(1);
        if (step && !branch_taken_i) begin
            for (int k = N_UNITS - 1; k >= 0; k--) begin
                if (!claimed && pc_i == u_bot[k] && u_cnt[k] != '0) begin
                    dec_v[k] = 1'b1;
                    if (u_cnt[k] != CW'(1)) begin
                        redirect_o = 1'b1;
                        target     = u_top[k];
                        claimed    = 1'b1;
                        pen_load   = u_arm[k];
                    end
                end
            end
        end
    end

    assign next_pc_o = target;

    always_comb begin
        st_d = st_q;
        if (st_q.pen != '0) st_d.pen = st_q.pen - PW'(1);
        else if (pen_load)  st_d.pen = PW'(PENALTY);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    loop_buffer #(.AW(AW), .IW(IW), .DEPTH(BUF_DEPTH)) i_buf (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .pc_i            (pc_i),
        .fill_i          (step),
        .data_i          (mem_data_i),
        .retarget_i      (setup_en_i || redirect_o),
        .retarget_addr_i (setup_en_i ? setup_top_i : target),
        .flush_i         (setup_en_i || reg_wr_en_i),
        .hit_o           (buf_hit),
        .data_o          (buf_data)
    );

    assign fetch_req_o = step && !buf_hit;
    assign instr_o     = buf_hit ? buf_data : mem_data_i;

    always_comb begin
        reg_rd_data_o = '0;
        if (int'(reg_rd_unit_i) < N_UNITS) begin
            case (lreg_sel_e'(reg_rd_sel_i))
                SEL_TOP: reg_rd_data_o = RW'(u_top[reg_rd_unit_i]);
                SEL_BOT: reg_rd_data_o = RW'(u_bot[reg_rd_unit_i]);
                SEL_CNT: reg_rd_data_o = RW'(u_cnt[reg_rd_unit_i]);
                default: reg_rd_data_o = '0;
            endcase
        end
    end

    // penalty cycles neither redirect nor fetch
    assert_stall_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> (!redirect_o && !fetch_req_o));

    // a taken branch overrides the loopback
    assert_branch_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pc_valid_i && branch_taken_i) |-> !redirect_o);

    // a penalty once started runs down without restarting
    assert_pen_runs_down_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && st_q.pen != PW'(1)) |=> stall_o);

    // a hit never asks memory for the word
    assert_hit_no_fetch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        buf_hit |-> !fetch_req_o);

endmodule

// File: tb/test_loop_ctl.sv
module test_loop_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_valid = 1'b0;
    logic [15:0] pc = '0;
    logic        branch = 1'b0;
    logic        su_en = 1'b0;
    logic        su_unit = 1'b0;
    logic [15:0] su_pc_s = '0, su_top_s = '0, su_bot_s = '0, su_cnt_s = '0;
    logic        wr_en = 1'b0;
    logic        wr_unit = 1'b0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        rd_unit = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;
    logic [31:0] mem_data = '0;
    logic        fetch_req, redirect, stall;
    logic [31:0] instr;
    logic [15:0] next_pc;

    always #5 clk = ~clk;

    loop_ctl i_loop_ctl (
        .clk_i(clk), .rst_ni(rst_n), .pc_valid_i(pc_valid), .pc_i(pc),
        .branch_taken_i(branch), .setup_en_i(su_en), .setup_unit_i(su_unit),
        .setup_pc_i(su_pc_s), .setup_top_i(su_top_s), .setup_bot_i(su_bot_s),
        .setup_cnt_i(su_cnt_s), .reg_wr_en_i(wr_en), .reg_wr_unit_i(wr_unit),
        .reg_wr_sel_i(wr_sel), .reg_wr_data_i(wr_data), .reg_rd_unit_i(rd_unit),
        .reg_rd_sel_i(rd_sel), .reg_rd_data_o(rd_data), .mem_data_i(mem_data),
        .fetch_req_o(fetch_req), .instr_o(instr), .redirect_o(redirect),
        .next_pc_o(next_pc), .stall_o(stall)
    );

    int n_tests = 0, n_fail = 0;
    logic [15:0] trace[$];
    int fetches, stalls, instr_bad;

    // program description for a run: up to four setups and one branch
    int          su_n = 0;
    logic [15:0] t_pc[4], t_top[4], t_bot[4], t_cnt[4];
    logic        t_unit[4];
    logic        br_arm = 1'b0;
    logic [15:0] br_pc = '0, br_tgt = '0;

    function automatic logic [31:0] code(input logic [15:0] a);
        return {a ^ 16'h5A5A, a};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic add_setup(input int j, input logic u, input logic [15:0] at,
                             input logic [15:0] top, input logic [15:0] bot,
                             input logic [15:0] cnt);
        t_pc[j] = at; t_unit[j] = u; t_top[j] = top; t_bot[j] = bot; t_cnt[j] = cnt;
        su_n = j + 1;
    endtask

    task automatic rd(input logic u, input logic [1:0] sel, output logic [15:0] v);
        rd_unit = u; rd_sel = sel; #1; v = rd_data;
    endtask

    task automatic wr(input logic u, input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk); wr_en = 1'b1; wr_unit = u; wr_sel = sel; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // step the fetch address as a sequencer would, honouring stall and redirect
    task automatic run(input logic [15:0] start, input logic [15:0] stop,
                       input int max_steps, output logic [15:0] pc_out);
        logic [15:0] cur = start;
        int steps = 0;
        int guard = 0;
        trace.delete(); fetches = 0; stalls = 0; instr_bad = 0;
        while (cur != stop && steps < max_steps && guard < 2000) begin
            @(negedge clk);
            guard++;
            su_en = 1'b0; branch = 1'b0;
            if (stall) begin
                pc_valid = 1'b0;
                stalls++;
            end else begin
                pc_valid = 1'b1; pc = cur;
                for (int j = 0; j < su_n; j++) begin
                    if (t_pc[j] == cur) begin
                        su_en = 1'b1; su_unit = t_unit[j]; su_pc_s = cur;
                        su_top_s = t_top[j]; su_bot_s = t_bot[j]; su_cnt_s = t_cnt[j];
                    end
                end
                if (br_arm && cur == br_pc) branch = 1'b1;
                #1;
                mem_data = fetch_req ? code(cur) : 32'hDEAD_BEEF;
                #1;
                if (instr != code(cur)) instr_bad++;
                if (fetch_req) fetches++;
                trace.push_back(cur);
                steps++;
                if (branch) begin cur = br_tgt; br_arm = 1'b0; end
                else cur = next_pc;
            end
        end
        @(negedge clk);
        pc_valid = 1'b0; su_en = 1'b0; branch = 1'b0;
        pc_out = cur;
    endtask

    task automatic cmp_trace(input string req, input logic [15:0] exp[$]);
        int bad = -1;
        if (trace.size() != exp.size()) begin
            check(1'b0, req, "trace length", trace.size(), exp.size());
            return;
        end
        foreach (exp[i]) if (bad < 0 && trace[i] != exp[i]) bad = i;
        if (bad < 0) check(1'b1, req, "trace", 0, 0);
        else check(1'b0, req, "trace entry", trace[bad], exp[bad]);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check(redirect == 1'b0, "R1", "redirect after reset", redirect, 0);
        check(stall == 1'b0, "R1", "stall after reset", stall, 0);
        rd(1'b0, 2'd2, v); check(v == 0, "R1", "unit0 count", v, 0);
        rd(1'b1, 2'd2, v); check(v == 0, "R1", "unit1 count", v, 0);
    endtask

    task automatic t_nested();
        logic [15:0] e[$];
        logic [15:0] v, endpc;
        su_n = 0;
        add_setup(0, 1'b0, 16'h10, 16'h11, 16'h16, 16'd3);
        add_setup(1, 1'b1, 16'h12, 16'h13, 16'h14, 16'd2);
        run(16'h10, 16'h17, 200, endpc);
        e.push_back(16'h10);
        for (int o = 0; o < 3; o++) begin
            e.push_back(16'h11); e.push_back(16'h12);
            for (int i = 0; i < 2; i++) begin e.push_back(16'h13); e.push_back(16'h14); end
            e.push_back(16'h15); e.push_back(16'h16);
        end
        cmp_trace("R2 R4", e);
        check(fetches == 19, "R10", "nested fetch count", fetches, 19);
        check(stalls == 0, "R8", "no stall for adjacent top", stalls, 0);
        rd(1'b0, 2'd2, v); check(v == 0, "R2", "outer count exhausted", v, 0);
        rd(1'b1, 2'd0, v); check(v == 16'h13, "R4", "inner top from setup", v, 16'h13);
    endtask

    task automatic t_short();
        logic [15:0] e[$];
        logic [15:0] endpc;
        su_n = 0;
        add_setup(0, 1'b0, 16'h20, 16'h21, 16'h24, 16'd5);
        run(16'h20, 16'h25, 200, endpc);
        e.push_back(16'h20);
        for (int p = 0; p < 5; p++) for (int a = 16'h21; a <= 16'h24; a++) e.push_back(16'(a));
        cmp_trace("R2", e);
        check(fetches == 5, "R9", "short loop fetch count", fetches, 5);
        check(instr_bad == 0, "R9", "buffer instruction words", instr_bad, 0);
    endtask

    task automatic t_zero();
        logic [15:0] e[$];
        logic [15:0] endpc;
        su_n = 0;
        add_setup(0, 1'b0, 16'h40, 16'h41, 16'h42, 16'd0);
        run(16'h40, 16'h43, 50, endpc);
        e.push_back(16'h40); e.push_back(16'h41); e.push_back(16'h42);
        cmp_trace("R3", e);
    endtask

    task automatic t_penalty();
        logic [15:0] e[$];
        logic [15:0] endpc;
        su_n = 0;
        add_setup(0, 1'b0, 16'h30, 16'h33, 16'h34, 16'd3);
        run(16'h30, 16'h35, 100, endpc);
        for (int a = 16'h30; a <= 16'h34; a++) e.push_back(16'(a));
        for (int p = 0; p < 2; p++) begin e.push_back(16'h33); e.push_back(16'h34); end
        cmp_trace("R8", e);
        check(stalls == 4, "R8", "first loopback stall cycles", stalls, 4);
    endtask

    task automatic t_branch();
        logic [15:0] e[$];
        logic [15:0] v, endpc;
        su_n = 0;
        add_setup(0, 1'b0, 16'h50, 16'h51, 16'h52, 16'd3);
        br_arm = 1'b1; br_pc = 16'h52; br_tgt = 16'h60;
        run(16'h50, 16'h60, 50, endpc);
        e.push_back(16'h50); e.push_back(16'h51); e.push_back(16'h52);
        cmp_trace("R7", e);
        rd(1'b0, 2'd2, v); check(v == 3, "R7", "count kept over branch", v, 3);
    endtask

    task automatic t_shared();
        logic [15:0] e[$];
        logic [15:0] v, endpc;
        su_n = 0;
        add_setup(0, 1'b0, 16'h70, 16'h71, 16'h73, 16'd2);
        add_setup(1, 1'b1, 16'h71, 16'h72, 16'h73, 16'd2);
        run(16'h70, 16'h74, 100, endpc);
        e.push_back(16'h70);
        for (int o = 0; o < 2; o++) begin
            e.push_back(16'h71);
            for (int i = 0; i < 2; i++) begin e.push_back(16'h72); e.push_back(16'h73); end
        end
        cmp_trace("R6", e);
        rd(1'b0, 2'd2, v); check(v == 0, "R6", "outer count after shared bottom", v, 0);
    endtask

    task automatic t_save();
        logic [15:0] e[$];
        logic [15:0] v, endpc, s_top, s_bot, s_cnt;
        su_n = 0;
        add_setup(0, 1'b0, 16'h80, 16'h81, 16'h82, 16'd4);
        run(16'h80, 16'hFFFF, 5, endpc);
        check(endpc == 16'h81, "R2", "paused at loop top", endpc, 16'h81);
        check(fetches == 3, "R9", "fetches before save", fetches, 3);
        rd(1'b0, 2'd0, s_top); rd(1'b0, 2'd1, s_bot); rd(1'b0, 2'd2, s_cnt);
        check(s_cnt == 2, "R5", "saved count", s_cnt, 2);
        check(s_top == 16'h81 && s_bot == 16'h82, "R5", "saved bounds", {s_top, s_bot}, 32'h0081_0082);
        wr(1'b0, 2'd1, 16'h99);
        rd(1'b0, 2'd1, v); check(v == 16'h99, "R5", "single bottom write", v, 16'h99);
        wr(1'b0, 2'd3, 16'h1234);
        rd(1'b0, 2'd3, v); check(v == 0, "R5", "select 3 reads zero", v, 0);
        rd(1'b0, 2'd0, v); check(v == 16'h81, "R5", "select 3 write ignored", v, 16'h81);
        wr(1'b0, 2'd0, s_top); wr(1'b0, 2'd1, s_bot); wr(1'b0, 2'd2, s_cnt);
        su_n = 0;
        run(16'h81, 16'h83, 50, endpc);
        for (int p = 0; p < 2; p++) begin e.push_back(16'h81); e.push_back(16'h82); end
        cmp_trace("R5", e);
        check(fetches == 2, "R10", "refetch after restore", fetches, 2);
        check(instr_bad == 0, "R9", "words after restore", instr_bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_nested();
        t_short();
        t_zero();
        t_penalty();
        t_branch();
        t_shared();
        t_save();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule